// File: doc/BRIEF.md
# Voting Oversampled Serial Byte Receiver

This block recovers bytes from an asynchronous serial line that idles high. A clock enable, `tick_en`, pulses at sixteen times the bit rate and paces all timing inside the block. The line first passes through a synchronizer. A falling edge seen while idle opens a frame. From that edge the block counts ticks to find the centre of the start bit. It then steps sixteen ticks per bit through eight data bits, which arrive least significant bit first, and through one stop bit.

Each bit is not taken from one sample at its centre. Three line samples are captured at separated ticks around the centre, and the majority of the three sets the bit. A short disturbance that corrupts one sample therefore has no effect. If the voted start bit turns out high, the event is treated as noise and the block goes back to idle without output. At the stop-bit decision the byte is presented with a one-cycle valid strobe, and a framing flag reports a stop bit that voted low. The block is idle again at once, so the next start edge can come before the nominal end of the stop bit.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset `rx_valid` and `rx_frame_err` are 0 and `rx_data` is 0x00.
- R2: A falling edge on `rx_line` while idle opens a frame: a low start bit, eight data bits with bit 0 first, then the stop bit. Each bit lasts 16 `tick_en` pulses. The received byte appears on `rx_data` with `rx_valid`.
- R3: `rx_valid` is high for exactly one clock cycle per accepted frame.
- R4: Ticks are numbered 1 to 16 within each bit, and the start bit begins at the detected edge. The samples at ticks 7, 8 and 9 are combined by majority. A disturbance that alters only one of these three samples, or only ticks outside them, does not change the bit. Tick counting advances only on cycles with `tick_en` high.
- R5: When two of the three samples of a bit (ticks 7 and 9) carry the inverted level, the received bit is inverted.
- R6: If the voted start bit is high, no byte is output and the block returns to idle. A following well-formed frame is received normally.
- R7: If the voted stop bit is low, the byte is still output and `rx_frame_err` is 1 during its `rx_valid` cycle. Otherwise `rx_frame_err` is 0. `rx_frame_err` is never high outside a `rx_valid` cycle.
- R8: The block is idle right after the stop-bit decision at tick 9. A start edge that arrives at tick 11 of the stop bit is received as a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Clock enable at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Received byte, updated with `rx_valid` |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_frame_err | output | 1 | Stop bit voted low for the byte now presented |

## Verification
The bench places inversions on precise ticks of a bit. It inverts only the centre tick, then ticks 7 and 9 together. A receiver that used a single centre sample would corrupt the first case, and one that miscounted the tick offsets would fail to invert the second. A start pulse four ticks long checks that a false start produces no byte. A receiver that did not vote on the start bit would emit a spurious byte, or would lose the frame that follows. A low stop bit must still deliver its byte with the framing flag set. A frame that follows a shortened stop bit checks that a receiver staying busy until tick 16 would drop the second byte.

// File: rtl/uart_vote_rx_pkg.sv
package uart_vote_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uart_vote_rx_sync.sv
module uart_vote_rx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         initial $fatal(1, "uart_vote_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/uart_vote_rx_voter.sv
module uart_vote_rx_voter
   import uart_vote_rx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int VOTE_TAPS  = 3,
   localparam int CNT_W     = $clog2(OVERSAMPLE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [CNT_W-1:0] tick_cnt,
   input  logic             din,
   output logic             voted
);

   // tick_cnt holds the number of ticks already seen in the bit, so the
   // sample of tick number k is taken when tick_cnt equals k-1.
   localparam int MID     = OVERSAMPLE / 2;
   localparam int CNT_EAR = MID - 2;
   localparam int CNT_CEN = MID - 1;

   generate
      if (VOTE_TAPS != 1 && VOTE_TAPS != 3) begin : g_bad_taps
         initial $fatal(1, "uart_vote_rx_voter: VOTE_TAPS must be 1 or 3");
      end
   endgenerate

   logic samp_cen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       samp_cen_q <= 1'b1;
      else if (tick_en && tick_cnt == CNT_W'(CNT_CEN))  samp_cen_q <= din;
   end

   generate
      if (VOTE_TAPS == 3) begin : g_vote3
         logic samp_ear_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      samp_ear_q <= 1'b1;
            else if (tick_en && tick_cnt == CNT_W'(CNT_EAR)) samp_ear_q <= din;
         end
         // the third sample is the live line at the decision tick
         assign voted = maj3(samp_ear_q, samp_cen_q, din);
      end else begin : g_vote1
         assign voted = samp_cen_q;
      end
   endgenerate

endmodule

// File: rtl/uart_vote_rx_shift.sv
module uart_vote_rx_shift #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             din,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         initial $fatal(1, "uart_vote_rx_shift: WIDTH must be at least 2");
      end
   endgenerate

   // first bit in ends at position 0 after WIDTH shifts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (shift_en) q <= {din, q[WIDTH-1:1]};
   end

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
   import uart_vote_rx_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2,
   parameter int VOTE_TAPS   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 rx_line,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 rx_frame_err
);

   localparam int CNT_W   = $clog2(OVERSAMPLE);
   localparam int BIT_W   = $clog2(DATA_BITS);
   localparam int MID     = OVERSAMPLE / 2;
   localparam int CNT_DEC = MID;
   localparam int CNT_END = OVERSAMPLE - 1;

   generate
      if (OVERSAMPLE < 8 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
         initial $fatal(1, "uart_vote_rx: OVERSAMPLE must be a power of two, at least 8");
      end
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_bits
         initial $fatal(1, "uart_vote_rx: DATA_BITS must lie in 5..9");
      end
   endgenerate

   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

   // line conditioning and edge detection
   logic rx_s;
   logic prev_q;
   logic fall;

   uart_vote_rx_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rx_line),
      .dout  (rx_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= rx_s;
   end

   assign fall = prev_q & ~rx_s;

   // bit timing
   rx_state_e        state_q, state_d;
   logic [CNT_W-1:0] tick_cnt_q;
   logic [BIT_W-1:0] bit_idx_q;
   logic             decide;
   logic             bit_end;
   logic             voted;
   logic             shift_en;
   logic [DATA_BITS-1:0] shift_q;

   assign decide  = tick_en && (tick_cnt_q == CNT_W'(CNT_DEC));
   assign bit_end = tick_en && (tick_cnt_q == CNT_W'(CNT_END));

   uart_vote_rx_voter #(
      .OVERSAMPLE (OVERSAMPLE),
      .VOTE_TAPS  (VOTE_TAPS)
   ) u_voter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .tick_cnt (tick_cnt_q),
      .din      (rx_s),
      .voted    (voted)
   );

   assign shift_en = (state_q == RX_DATA) && decide;

   uart_vote_rx_shift #(
      .WIDTH (DATA_BITS)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (voted),
      .q        (shift_q)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RX_IDLE:  if (fall) state_d = RX_START;
         RX_START: begin
            if (decide && voted) state_d = RX_IDLE;
            else if (bit_end)    state_d = RX_DATA;
         end
         RX_DATA:  if (bit_end && bit_idx_q == LAST_BIT) state_d = RX_STOP;
         RX_STOP:  if (decide) state_d = RX_IDLE;
         default:  state_d = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RX_IDLE;
         tick_cnt_q <= '0;
         bit_idx_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == RX_IDLE) begin
            tick_cnt_q <= '0;
            bit_idx_q  <= '0;
         end else begin
            if (tick_en) tick_cnt_q <= tick_cnt_q + CNT_W'(1);
            if (state_q == RX_DATA && bit_end && bit_idx_q != LAST_BIT)
               bit_idx_q <= bit_idx_q + BIT_W'(1);
         end
      end
   end

   // output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data      <= '0;
         rx_valid     <= 1'b0;
         rx_frame_err <= 1'b0;
      end else begin
         rx_valid     <= 1'b0;
         rx_frame_err <= 1'b0;
         if (state_q == RX_STOP && decide) begin
            rx_data      <= shift_q;
            rx_valid     <= 1'b1;
            rx_frame_err <= ~voted;
         end
      end
   end

endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk
   import uart_vote_rx_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             rx_valid,
   input logic             rx_frame_err,
   input rx_state_e        state,
   input logic [CNT_W-1:0] tick_cnt
);

   assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_err_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_frame_err |-> rx_valid);

   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_IDLE) |=> !rx_valid);

   assert_count_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state != RX_IDLE && !tick_en) |=> $stable(tick_cnt));

   assert_valid_from_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(state) == RX_STOP);

endmodule

bind uart_vote_rx uart_vote_rx_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_en      (tick_en),
   .rx_valid     (rx_valid),
   .rx_frame_err (rx_frame_err),
   .state        (state_q),
   .tick_cnt     (tick_cnt_q)
);

// File: tb/test_uart_vote_rx.sv
module test_uart_vote_rx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       rx_line = 1'b1;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_frame_err;

   always #10 clk = ~clk;

   uart_vote_rx i_uart_vote_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_en      (tick_en),
      .rx_line      (rx_line),
      .rx_data      (rx_data),
      .rx_valid     (rx_valid),
      .rx_frame_err (rx_frame_err)
   );

   int checks = 0;
   int errors = 0;
   int valid_cnt = 0;
   int exp_valid = 0;
   logic [7:0] cap_data = 8'h00;
   logic       cap_err = 1'b0;
   logic       done = 1'b0;

   always @(negedge clk) begin
      if (rx_valid) begin
         valid_cnt = valid_cnt + 1;
         cap_data  = rx_data;
         cap_err   = rx_frame_err;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one slot = one tick period = 4 clocks; a tick accompanies each slot
   task automatic slot(input logic v);
      @(negedge clk);
      rx_line <= v;
      tick_en <= 1'b1;
      @(negedge clk);
      tick_en <= 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) slot(1'b1);
   endtask

   // masks: 16 bits per data bit, a 1 inverts that slot
   task automatic send_frame(input logic [7:0] b, input logic [127:0] m,
                             input logic stop_v, input int stop_slots);
      for (int s = 0; s < 16; s++) slot(1'b0);
      for (int i = 0; i < 8; i++)
         for (int s = 0; s < 16; s++) slot(b[i] ^ m[i*16+s]);
      for (int s = 0; s < stop_slots; s++) slot(stop_v);
   endtask

   // the design samples slots 6, 7, 8 of a bit (ticks 7, 8, 9)
   function automatic logic [7:0] exp_byte(input logic [7:0] b, input logic [127:0] m);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) begin
         logic a0, a1, a2;
         a0 = b[i] ^ m[i*16+6];
         a1 = b[i] ^ m[i*16+7];
         a2 = b[i] ^ m[i*16+8];
         r[i] = (a0 & a1) | (a0 & a2) | (a1 & a2);
      end
      return r;
   endfunction

   task automatic check_frame(input string req, input logic [7:0] d, input logic e);
      @(posedge clk);
      #1;
      exp_valid++;
      check({req, " valid count"}, valid_cnt, exp_valid);
      check({req, " data"}, cap_data, d);
      check({req, " frame_err"}, cap_err, e);
   endtask

   initial begin
      logic [127:0] m;
      logic [7:0]   b;
      void'($urandom(32'h5EED_1234));

      idle(3);
      @(negedge clk);
      rst_n <= 1'b1;
      @(posedge clk);
      #1;
      // R1 reset state
      check("R1 rx_valid", rx_valid, 0);
      check("R1 rx_frame_err", rx_frame_err, 0);
      check("R1 rx_data", rx_data, 0);
      idle(4);

      // R2 clean frame
      send_frame(8'h55, '0, 1'b1, 16);
      check_frame("R2 0x55", 8'h55, 1'b0);
      idle(3);
      send_frame(8'hC4, '0, 1'b1, 16);
      check_frame("R2 0xC4", 8'hC4, 1'b0);
      idle(2);

      // R8 shortened stop followed immediately by the next start
      send_frame(8'h3C, '0, 1'b1, 10);
      check_frame("R8 first", 8'h3C, 1'b0);
      send_frame(8'h96, '0, 1'b1, 16);
      check_frame("R8 second", 8'h96, 1'b0);
      idle(2);

      // R4 centre sample inverted on every bit
      m = '0;
      for (int i = 0; i < 8; i++) m[i*16+7] = 1'b1;
      send_frame(8'hA5, m, 1'b1, 16);
      check_frame("R4 centre glitch", 8'hA5, 1'b0);
      idle(2);

      // R4 inversions on non-sampled ticks
      m = '0;
      for (int i = 0; i < 8; i++) begin
         m[i*16+4] = 1'b1;
         m[i*16+10] = 1'b1;
      end
      send_frame(8'h5A, m, 1'b1, 16);
      check_frame("R4 outer glitch", 8'h5A, 1'b0);
      idle(2);

      // R5 two of three samples inverted on bits 0 and 3
      m = '0;
      m[0*16+6] = 1'b1; m[0*16+8] = 1'b1;
      m[3*16+6] = 1'b1; m[3*16+8] = 1'b1;
      send_frame(8'h0F, m, 1'b1, 16);
      check_frame("R5 double glitch", 8'h06, 1'b0);
      idle(2);

      // R6 false start: four ticks low
      for (int s = 0; s < 4; s++) slot(1'b0);
      idle(24);
      @(posedge clk);
      #1;
      check("R6 no output", valid_cnt, exp_valid);
      send_frame(8'h81, '0, 1'b1, 16);
      check_frame("R6 recovery", 8'h81, 1'b0);
      idle(2);

      // R7 low stop bit
      send_frame(8'h7E, '0, 1'b0, 16);
      check_frame("R7 framing error", 8'h7E, 1'b1);
      idle(4);
      send_frame(8'hE7, '0, 1'b1, 16);
      check_frame("R7 clean after error", 8'hE7, 1'b0);
      idle(2);

      // random frames with single-sample noise (R2, R4)
      for (int f = 0; f < 30; f++) begin
         b = 8'($urandom);
         m = '0;
         for (int i = 0; i < 8; i++)
            if ($urandom % 3 != 0) m[i*16 + int'($urandom % 16)] = 1'b1;
         send_frame(b, m, 1'b1, ($urandom % 2 == 0) ? 16 : 10);
         check_frame("R4 random", exp_byte(b, m), 1'b0);
         if ($urandom % 2 == 0) idle(1 + int'($urandom % 5));
      end

      idle(4);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule